// File: doc/BRIEF.md
# Legacy Audio I/O Address Decoder

This block sits behind the I/O target path of an audio controller and decides which of four compatibility functions, if any, owns an I/O cycle. The four functions are an FM synthesizer, a DSP block in the style of the classic PC sound card, a MIDI port in UART style and a game port. Each function has a 2-bit base-select input that picks its window base from a fixed list of four addresses. A per-function enable gates each window. An alias-mode input chooses whether 10 or all 16 address bits take part in the compare. A global disable switches the whole decoder off.

For a qualifying cycle the decoder produces a one-hot function select, the byte offset inside the chosen window and a claim flag that the bus interface uses to drive its device-select response. The FM register file can also be reached through part of the DSP window, so FM accesses still work while the dedicated FM window is turned off. All outputs are registered and appear one clock after the address is presented.

Top module: `legacy_io_decode`

## Requirements
- R1: FM window: base select 0/1/2/3 gives base 388h/398h/3A0h/3A8h; the window is 4 bytes; a hit sets select bit 0 and the offset output carries address minus base (0..3).
- R2: DSP window: base select 0/1/2/3 gives 220h/240h/260h/280h; the window is 16 bytes; a hit on a DSP-owned offset sets select bit 1 with offset 0..15.
- R3: MIDI window: base select 0/1/2/3 gives 330h/300h/332h/334h; the window is 2 bytes; a hit sets select bit 2 with offset 0 or 1.
- R4: Game port window: base select 0/1/2/3 gives 201h/202h/204h/205h; the window is 1 byte; a hit sets select bit 3 with offset 0.
- R5: With the alias input at 1, only address bits 9:0 are compared and bits 15:10 are ignored; with it at 0, all 16 bits must match the window.
- R6: While the global disable input is 1, no cycle is claimed and the select and offset outputs stay 0.
- R7: A function's window is claimed only while that function's enable is 1; the direct FM window needs the FM enable.
- R8: While the DSP enable is 1, DSP window offsets 0h-3h and 8h-9h select the FM function (select bit 0) with FM offset equal to the DSP offset modulo 4, whatever the FM enable; the other DSP offsets go to the DSP block.
- R9: Only cycles with the valid strobe at 1 and command code 0010b (I/O read) or 0011b (I/O write) can be claimed; every other code is never claimed.
- R10: Select, offset and claim are registered: they reflect the inputs of the previous clock edge. At most one select bit is 1, claim equals the OR of the select bits, offset is 0 when nothing is claimed, and all three are 0 after synchronous reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Address phase strobe for the current cycle |
| io_cmd | input | 4 | Bus command code of the cycle |
| io_addr | input | 16 | I/O address |
| cfg_disable | input | 1 | Global legacy disable (1 = nothing claimed) |
| cfg_alias10 | input | 1 | 1 = compare bits 9:0 only, 0 = compare all 16 bits |
| en_fm | input | 1 | FM window enable |
| en_dsp | input | 1 | DSP window enable |
| en_midi | input | 1 | MIDI window enable |
| en_game | input | 1 | Game port window enable |
| base_fm | input | 2 | FM base select |
| base_dsp | input | 2 | DSP base select |
| base_midi | input | 2 | MIDI base select |
| base_game | input | 2 | Game port base select |
| hit_sel | output | 4 | One-hot select: bit0 FM, bit1 DSP, bit2 MIDI, bit3 game |
| hit_offset | output | 4 | Byte offset inside the selected function |
| hit_claim | output | 1 | Cycle is claimed by this decoder |

## Verification
The bench sweeps every address around the whole legacy range, under every base-select setting, both compare widths and several enable patterns. It pays most attention to the window edges: one byte below each base and one byte past its end. A design with an off-by-one window would claim a neighbour's address or drop the last byte. The DSP window offsets 4h-7h and Ah-Fh lie next to the routed FM offsets, and a wrong routing mask would send them to the wrong function or carry an unreduced offset. Addresses with upper bits set are replayed in both compare modes, which catches a decoder that ignores the alias input. Every command code is tried against live windows, so a decoder that claims memory or configuration cycles is caught.

// File: rtl/legacy_io_pkg.sv
package legacy_io_pkg;

  localparam int NUM_FN   = 4;
  localparam int IDX_FM   = 0;
  localparam int IDX_DSP  = 1;
  localparam int IDX_MIDI = 2;
  localparam int IDX_GAME = 3;

  localparam logic [3:0] CMD_IO_RD = 4'b0010;
  localparam logic [3:0] CMD_IO_WR = 4'b0011;

  // Base address for a function and its 2-bit selector.
  function automatic logic [15:0] fn_base(input int fn, input logic [1:0] s);
    logic [15:0] b;
    b = 16'h0000;
    case (fn)
      IDX_FM: begin
        case (s)
          2'd0: b = 16'h0388;
          2'd1: b = 16'h0398;
          2'd2: b = 16'h03A0;
          default: b = 16'h03A8;
        endcase
      end
      IDX_DSP: b = 16'h0220 + {9'd0, s, 5'd0};
      IDX_MIDI: begin
        case (s)
          2'd0: b = 16'h0330;
          2'd1: b = 16'h0300;
          2'd2: b = 16'h0332;
          default: b = 16'h0334;
        endcase
      end
      default: begin
        case (s)
          2'd0: b = 16'h0201;
          2'd1: b = 16'h0202;
          2'd2: b = 16'h0204;
          default: b = 16'h0205;
        endcase
      end
    endcase
    return b;
  endfunction

  // Window size in bytes for a function.
  function automatic logic [4:0] fn_span(input int fn);
    case (fn)
      IDX_FM:   return 5'd4;
      IDX_DSP:  return 5'd16;
      IDX_MIDI: return 5'd2;
      default:  return 5'd1;
    endcase
  endfunction

endpackage

// File: rtl/io_window_match.sv
module io_window_match #(
  parameter int ADDR_W  = 16,
  parameter int ALIAS_W = 10,
  parameter int OFS_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W:0]    span,
  input  logic              alias_short,
  output logic              hit,
  output logic [OFS_W-1:0]  offset
);

  localparam int PAD_W = ADDR_W - ALIAS_W;

  logic [ADDR_W-1:0]  diff_full;
  logic [ALIAS_W-1:0] diff_low;
  logic [ADDR_W-1:0]  diff_sel;
  logic [ADDR_W-1:0]  span_ext;

  always_comb begin
    diff_full = addr - base;
    diff_low  = addr[ALIAS_W-1:0] - base[ALIAS_W-1:0];
    diff_sel  = alias_short ? {{PAD_W{1'b0}}, diff_low} : diff_full;
    span_ext  = {{(ADDR_W-OFS_W-1){1'b0}}, span};
    hit       = (diff_sel < span_ext);
    offset    = diff_sel[OFS_W-1:0];
  end

endmodule

// File: rtl/io_fn_router.sv
module io_fn_router #(
  parameter int NFN   = 4,
  parameter int OFS_W = 4
) (
  input  logic [NFN-1:0]            win_hit,
  input  logic [NFN-1:0][OFS_W-1:0] win_ofs,
  input  logic [NFN-1:0]            fn_en,
  input  logic                      cycle_ok,
  output logic [NFN-1:0]            sel,
  output logic [OFS_W-1:0]          ofs,
  output logic                      claim
);
  import legacy_io_pkg::*;

  logic [OFS_W-1:0] dsp_ofs;
  logic             dsp_live;
  logic             dsp_to_fm;

  always_comb begin
    dsp_ofs   = win_ofs[IDX_DSP];
    dsp_live  = cycle_ok && win_hit[IDX_DSP] && fn_en[IDX_DSP];
    // FM register pairs mirrored at DSP offsets 0..3 and 8..9
    dsp_to_fm = (dsp_ofs[3:2] == 2'b00) || (dsp_ofs[3:1] == 3'b100);
    sel = '0;
    ofs = '0;
    if (dsp_live) begin
      if (dsp_to_fm) begin
        sel[IDX_FM] = 1'b1;
        ofs = {{(OFS_W-2){1'b0}}, dsp_ofs[1:0]};
      end else begin
        sel[IDX_DSP] = 1'b1;
        ofs = dsp_ofs;
      end
    end else if (cycle_ok && win_hit[IDX_FM] && fn_en[IDX_FM]) begin
      sel[IDX_FM] = 1'b1;
      ofs = win_ofs[IDX_FM];
    end else if (cycle_ok && win_hit[IDX_MIDI] && fn_en[IDX_MIDI]) begin
      sel[IDX_MIDI] = 1'b1;
      ofs = win_ofs[IDX_MIDI];
    end else if (cycle_ok && win_hit[IDX_GAME] && fn_en[IDX_GAME]) begin
      sel[IDX_GAME] = 1'b1;
      ofs = win_ofs[IDX_GAME];
    end
    claim = |sel;
  end

endmodule

// File: rtl/legacy_io_decode.sv
module legacy_io_decode #(
  parameter int ADDR_W  = 16,
  parameter int ALIAS_W = 10,
  parameter int OFS_W   = 4,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_valid,
  input  logic [3:0]        io_cmd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              cfg_disable,
  input  logic              cfg_alias10,
  input  logic              en_fm,
  input  logic              en_dsp,
  input  logic              en_midi,
  input  logic              en_game,
  input  logic [SEL_W-1:0]  base_fm,
  input  logic [SEL_W-1:0]  base_dsp,
  input  logic [SEL_W-1:0]  base_midi,
  input  logic [SEL_W-1:0]  base_game,
  output logic [3:0]        hit_sel,
  output logic [OFS_W-1:0]  hit_offset,
  output logic              hit_claim
);
  import legacy_io_pkg::*;

  localparam int NFN = NUM_FN;

  logic [NFN-1:0][SEL_W-1:0] base_sel;
  logic [NFN-1:0]            fn_en;
  logic [NFN-1:0]            win_hit;
  logic [NFN-1:0][OFS_W-1:0] win_ofs;
  logic                      cycle_ok;
  logic [NFN-1:0]            sel_d;
  logic [OFS_W-1:0]          ofs_d;
  logic                      claim_d;

  always_comb begin
    base_sel[IDX_FM]   = base_fm;
    base_sel[IDX_DSP]  = base_dsp;
    base_sel[IDX_MIDI] = base_midi;
    base_sel[IDX_GAME] = base_game;
    fn_en[IDX_FM]      = en_fm;
    fn_en[IDX_DSP]     = en_dsp;
    fn_en[IDX_MIDI]    = en_midi;
    fn_en[IDX_GAME]    = en_game;
    cycle_ok = io_valid && !cfg_disable &&
               ((io_cmd == CMD_IO_RD) || (io_cmd == CMD_IO_WR));
  end

  for (genvar g = 0; g < NFN; g++) begin : g_win
    logic [ADDR_W-1:0] base_addr;
    logic [OFS_W:0]    span;
    always_comb begin
      base_addr = ADDR_W'(fn_base(g, base_sel[g]));
      span      = (OFS_W+1)'(fn_span(g));
    end
    io_window_match #(
      .ADDR_W (ADDR_W),
      .ALIAS_W(ALIAS_W),
      .OFS_W  (OFS_W)
    ) match_i (
      .addr       (io_addr),
      .base       (base_addr),
      .span       (span),
      .alias_short(cfg_alias10),
      .hit        (win_hit[g]),
      .offset     (win_ofs[g])
    );
  end

  io_fn_router #(
    .NFN  (NFN),
    .OFS_W(OFS_W)
  ) router_i (
    .win_hit (win_hit),
    .win_ofs (win_ofs),
    .fn_en   (fn_en),
    .cycle_ok(cycle_ok),
    .sel     (sel_d),
    .ofs     (ofs_d),
    .claim   (claim_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_sel    <= '0;
      hit_offset <= '0;
      hit_claim  <= 1'b0;
    end else begin
      hit_sel    <= sel_d;
      hit_offset <= ofs_d;
      hit_claim  <= claim_d;
    end
  end

endmodule

// File: rtl/legacy_io_decode_chk.sv
module legacy_io_decode_chk (
  input logic        clk,
  input logic        rst,
  input logic        io_valid,
  input logic [3:0]  io_cmd,
  input logic        cfg_disable,
  input logic        en_fm,
  input logic        en_dsp,
  input logic        en_midi,
  input logic        en_game,
  input logic [3:0]  hit_sel,
  input logic [3:0]  hit_offset,
  input logic        hit_claim
);

  assert_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_sel));

  assert_claim_sel_R10: assert property (@(posedge clk) disable iff (rst)
    hit_claim |-> (hit_sel != 4'd0));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !hit_claim |-> (hit_sel == 4'd0 && hit_offset == 4'd0));

  assert_disable_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_disable)) |-> !hit_claim);

  assert_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(io_valid) &&
      ($past(io_cmd) == 4'b0010 || $past(io_cmd) == 4'b0011))) |-> !hit_claim);

  assert_fm_ofs_R1: assert property (@(posedge clk) disable iff (rst)
    hit_sel[0] |-> (hit_offset[3:2] == 2'b00));

  assert_midi_ofs_R3: assert property (@(posedge clk) disable iff (rst)
    hit_sel[2] |-> (hit_offset[3:1] == 3'b000));

  assert_game_ofs_R4: assert property (@(posedge clk) disable iff (rst)
    hit_sel[3] |-> (hit_offset == 4'd0));

  assert_enable_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((!$past(en_dsp) -> !hit_sel[1]) &&
                     (!$past(en_midi) -> !hit_sel[2]) &&
                     (!$past(en_game) -> !hit_sel[3])));

  assert_fm_path_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en_fm) && !$past(en_dsp)) |-> !hit_sel[0]);

endmodule

bind legacy_io_decode legacy_io_decode_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .io_valid   (io_valid),
  .io_cmd     (io_cmd),
  .cfg_disable(cfg_disable),
  .en_fm      (en_fm),
  .en_dsp     (en_dsp),
  .en_midi    (en_midi),
  .en_game    (en_game),
  .hit_sel    (hit_sel),
  .hit_offset (hit_offset),
  .hit_claim  (hit_claim)
);

// File: tb/legacy_io_decode_tb.sv
module legacy_io_decode_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_valid = 1'b0;
  logic [3:0]  io_cmd = 4'd0;
  logic [15:0] io_addr = 16'd0;
  logic        cfg_disable = 1'b1;
  logic        cfg_alias10 = 1'b1;
  logic        en_fm = 1'b0, en_dsp = 1'b0, en_midi = 1'b0, en_game = 1'b0;
  logic [1:0]  base_fm = 2'd0, base_dsp = 2'd0, base_midi = 2'd0, base_game = 2'd0;
  logic [3:0]  hit_sel;
  logic [3:0]  hit_offset;
  logic        hit_claim;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  legacy_io_decode dut_i (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_cmd(io_cmd), .io_addr(io_addr),
    .cfg_disable(cfg_disable), .cfg_alias10(cfg_alias10),
    .en_fm(en_fm), .en_dsp(en_dsp), .en_midi(en_midi), .en_game(en_game),
    .base_fm(base_fm), .base_dsp(base_dsp), .base_midi(base_midi), .base_game(base_game),
    .hit_sel(hit_sel), .hit_offset(hit_offset), .hit_claim(hit_claim)
  );

  function automatic logic [15:0] tb_base(input int fn, input logic [1:0] s);
    logic [15:0] fm_t[4]   = '{16'h388, 16'h398, 16'h3A0, 16'h3A8};
    logic [15:0] dsp_t[4]  = '{16'h220, 16'h240, 16'h260, 16'h280};
    logic [15:0] midi_t[4] = '{16'h330, 16'h300, 16'h332, 16'h334};
    logic [15:0] game_t[4] = '{16'h201, 16'h202, 16'h204, 16'h205};
    case (fn)
      0: return fm_t[s];
      1: return dsp_t[s];
      2: return midi_t[s];
      default: return game_t[s];
    endcase
  endfunction

  // Expected {claim, sel[3:0], offset[3:0]} plus the requirement the case exercises.
  task automatic expect_of(output logic [8:0] exp, output string tag);
    int a, b, off;
    bit ok;
    logic [3:0] sel;
    logic [3:0] ofs;
    int spans[4] = '{4, 16, 2, 1};
    logic [3:0] en;
    logic [1:0] bs[4];
    en = {en_game, en_midi, en_dsp, en_fm};
    bs[0] = base_fm; bs[1] = base_dsp; bs[2] = base_midi; bs[3] = base_game;
    sel = 4'd0; ofs = 4'd0;
    ok = io_valid && (io_cmd == 4'b0010 || io_cmd == 4'b0011);
    a = cfg_alias10 ? int'(io_addr[9:0]) : int'(io_addr);
    tag = "R10";
    if (ok && !cfg_disable) begin
      for (int f = 0; f < 4; f++) begin
        b = int'(tb_base(f, bs[f]));
        if (a >= b && a < b + spans[f] && en[f]) begin
          off = a - b;
          if (f == 1 && (off < 4 || off == 8 || off == 9)) begin
            sel = 4'b0001; ofs = 4'(off % 4); tag = "R8";
          end else begin
            sel = 4'(1 << f); ofs = 4'(off);
            tag = (f == 0) ? "R1" : (f == 1) ? "R2" : (f == 2) ? "R3" : "R4";
          end
        end
      end
      if (sel == 4'd0 && en != 4'hF) tag = "R7";
      if (cfg_alias10 == 1'b0 && io_addr[15:10] != 6'd0) tag = "R5";
      if (cfg_alias10 == 1'b1 && io_addr[15:10] != 6'd0 && sel != 4'd0) tag = "R5";
    end else if (!ok) begin
      tag = "R9";
    end else begin
      tag = "R6";
    end
    exp = {(sel != 4'd0), sel, ofs};
  endtask

  // Inputs are set at a falling edge; the registered result is sampled one cycle later.
  task automatic run_vec();
    logic [8:0] exp;
    string tag;
    logic [8:0] act;
    expect_of(exp, tag);
    @(posedge clk);
    @(negedge clk);
    act = {hit_claim, hit_sel, hit_offset};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h cmd=%b act claim/sel/ofs=%b/%b/%h exp=%b/%b/%h",
               tag, io_addr, io_cmd, act[8], act[7:4], act[3:0], exp[8], exp[7:4], exp[3:0]);
    end
  endtask

  task automatic sweep(input logic [15:0] upper);
    for (int ad = 16'h1F8; ad < 16'h3B8; ad++) begin
      io_addr = 16'(ad) ^ upper;
      run_vec();
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] pats[4] = '{4'b1111, 4'b1110, 4'b1101, 4'b0011};
    repeat (3) @(negedge clk);
    // R10: reset state
    n_vec++;
    if ({hit_claim, hit_sel, hit_offset} !== 9'd0) begin
      n_bad++;
      $display("FAIL R10 reset act=%b exp=0", {hit_claim, hit_sel, hit_offset});
    end
    rst = 1'b0;
    io_valid = 1'b1;
    io_cmd = 4'b0010;

    // R6: global disable with every window live
    cfg_disable = 1'b1;
    {en_game, en_midi, en_dsp, en_fm} = 4'hF;
    sweep(16'h0000);

    // R1..R5, R7, R8: windows under all selectors, both compare widths, enable patterns
    cfg_disable = 1'b0;
    for (int s = 0; s < 4; s++) begin
      for (int al = 0; al < 2; al++) begin
        for (int p = 0; p < 4; p++) begin
          base_fm = 2'(s); base_dsp = 2'(s + 1); base_midi = 2'(s + 2); base_game = 2'(s + 3);
          cfg_alias10 = al[0];
          {en_game, en_midi, en_dsp, en_fm} = pats[p];
          io_cmd = (p[0]) ? 4'b0011 : 4'b0010;
          sweep(16'h0000);
          sweep(16'hA400);
        end
      end
    end

    // R9: every command code, and a dropped strobe, against live windows
    {en_game, en_midi, en_dsp, en_fm} = 4'hF;
    base_fm = 2'd0; base_dsp = 2'd0; base_midi = 2'd0; base_game = 2'd0;
    cfg_alias10 = 1'b1;
    for (int c = 0; c < 16; c++) begin
      for (int v = 0; v < 2; v++) begin
        io_cmd = 4'(c);
        io_valid = v[0];
        io_addr = 16'h0389; run_vec();
        io_addr = 16'h0224; run_vec();
        io_addr = 16'h0331; run_vec();
        io_addr = 16'h0201; run_vec();
      end
    end

    // R10: reset clears a live claim
    io_valid = 1'b1; io_cmd = 4'b0011; io_addr = 16'h0201;
    @(posedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if ({hit_claim, hit_sel, hit_offset} !== 9'd0) begin
      n_bad++;
      $display("FAIL R10 reset after hit act=%b exp=0", {hit_claim, hit_sel, hit_offset});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule